// File: doc/BRIEF.md
# Serial Configuration Image Loader

After reset the loader wakes up by itself and reads a serial configuration EEPROM from its first word to its last, using a single read command followed by one unbroken stream of data bits. The leading words fill the internal configuration state: four board identification bytes and a control word. The control word carries an enable for an external station-address PROM and an enable for the host window that exposes the identification bytes. The trailing words are not used inside the block. They exist only so that an external shift register, clocked by the same serial clock and fed from the EEPROM data-out line, can collect them.

A 16-bit checksum covers every word of the image. When the sum is correct, the block commits the configuration and drops its busy line. External logic uses that falling edge as the latch strobe for its shift register. When the sum is wrong, busy stays high for good, the configuration outputs keep their reset values, and a board with a bad EEPROM is easy to spot.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, and right after it, busy is 1, chip select, serial clock and data-in are 0, and every configuration output is 0. A load then starts with no further stimulus.
- R2: While chip select is 1, every high phase and every low phase of the serial clock lasts exactly DIV system clocks. While chip select is 0, the serial clock is 0.
- R3: The first 3+ADDR_W bits on data-in, as sampled at rising serial-clock edges, are 1, 1, 0 and then ADDR_W zeros, so word 0 is read. Only one command is sent per load.
- R4: After the command there is one dummy edge. Then 16*NWORDS data bits are taken at successive rising edges, word 0 first and each word MSB first. A load uses exactly 4+ADDR_W+16*NWORDS rising edges, and chip select then falls.
- R5: Busy is high from reset for as long as the EEPROM is read. If the 16-bit sum of all words equals SUM_OK, busy falls exactly one system clock after chip select falls and then stays low until the next reset.
- R6: If the sum differs from SUM_OK, busy stays high indefinitely and the configuration outputs stay 0.
- R7: Image layout: word 0 holds identification bytes 0 (bits 7:0) and 1 (bits 15:8); word 1 holds bytes 2 and 3 in the same way; word 2 is control, with bit 0 the address-PROM enable and bit 10 the identification window enable; word 3 is free for checksum adjustment; words 4 and up form the external chain. The outputs take these values only when the checksum passes.
- R8: A host read whose address is in ID_BASE..ID_BASE+3 while the window enable is 1 gives hit = 1 and data = identification byte (address − ID_BASE). Every other read, or any read while the enable is 0, gives hit = 0 and data = 0.
- R9: A 16*(NWORDS−4)-bit shift register that shifts in data-out on each rising serial-clock edge holds exactly the external-chain words, word 4 oldest, at the falling edge of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | Serial clock to the EEPROM and external chain |
| ee_di | output | 1 | Serial command data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| ld_busy | output | 1 | High while loading; falls on a good checksum |
| id_bytes | output | 32 | Identification bytes, byte 0 in bits 7:0 |
| aprom_en | output | 1 | Station address served by external PROM |
| id_win_en | output | 1 | Identification host window enabled |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 16 | Host I/O address |
| host_hit | output | 1 | Read decoded by the identification window |
| host_data | output | 8 | Read data for a hit, else 0 |

## Verification
The bench builds the loader with DIV=2, ADDR_W=6 and NWORDS=6. That keeps a full load near 430 system clocks, so a good image, a corrupted image and a second good image with different field values all fit in one short run. Six words leave a 32-bit external chain, which is long enough that a slip of one bit in the data stream changes the latched chain value and the loaded identification bytes. Using DIV=2 rather than 1 keeps the high and low phases distinct, so the phase-length check has a real count to compare against.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int unsigned WORD_W         = 16;
  localparam int unsigned W_CTRL         = 2;
  localparam int unsigned CTRL_APROM_BIT = 0;
  localparam int unsigned CTRL_IDWIN_BIT = 10;

  typedef enum logic [1:0] {LD_WAKE, LD_SHIFT, LD_CHECK, LD_HALT} ld_state_e;
endpackage

// File: rtl/cfgld_tick.sv
module cfgld_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NWORDS = 8,
  parameter logic [15:0] SUM_OK = 16'hBABA,
  localparam int unsigned CMD_W = 3 + ADDR_W,
  localparam int unsigned TOTAL = CMD_W + 1 + WORD_W * NWORDS,
  localparam int unsigned EW    = $clog2(TOTAL + 1),
  localparam int unsigned WIW   = EW - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              word_vld,
  output logic [WIW-1:0]    word_idx,
  output logic [WORD_W-1:0] word_data,
  output logic              pass,
  output logic              busy
);
  localparam logic [CMD_W-1:0] CMD = {3'b110, {ADDR_W{1'b0}}};

  ld_state_e         st_q, st_d;
  logic              cs_q, cs_d, sk_q, sk_d, di_q, di_d, busy_q, busy_d;
  logic [EW-1:0]     edge_q, edge_d, didx;
  logic [WORD_W-1:0] sh_q, sh_d, sum_q, sum_d;
  logic              sample;

  always_comb begin
    didx      = edge_q - EW'(CMD_W + 1);
    sample    = (st_q == LD_SHIFT) && tick && !sk_q && (edge_q >= EW'(CMD_W + 1));
    word_data = {sh_q[WORD_W-2:0], ee_do};
    word_idx  = didx[EW-1:4];
    word_vld  = sample && (didx[3:0] == 4'hF);
    pass      = (st_q == LD_CHECK) && (sum_q == SUM_OK);

    st_d = st_q; cs_d = cs_q; sk_d = sk_q; di_d = di_q;
    busy_d = busy_q; edge_d = edge_q; sh_d = sh_q; sum_d = sum_q;

    unique case (st_q)
      LD_WAKE: if (tick) begin
        cs_d   = 1'b1;
        di_d   = CMD[CMD_W-1];
        edge_d = '0;
        sum_d  = '0;
        st_d   = LD_SHIFT;
      end
      LD_SHIFT: if (tick) begin
        if (!sk_q) begin
          sk_d   = 1'b1;
          edge_d = edge_q + EW'(1);
          if (sample)   sh_d  = word_data;
          if (word_vld) sum_d = sum_q + word_data;
        end else begin
          sk_d = 1'b0;
          if (edge_q == EW'(TOTAL)) begin
            cs_d = 1'b0;
            di_d = 1'b0;
            st_d = LD_CHECK;
          end else begin
            di_d = (edge_q < EW'(CMD_W)) ? CMD[CMD_W - 1 - int'(edge_q)] : 1'b0;
          end
        end
      end
      LD_CHECK: begin
        if (pass) busy_d = 1'b0;
        st_d = LD_HALT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LD_WAKE; cs_q <= 1'b0; sk_q <= 1'b0; di_q <= 1'b0; busy_q <= 1'b1;
      edge_q <= '0; sh_q <= '0; sum_q <= '0;
    end else begin
      st_q <= st_d; cs_q <= cs_d; sk_q <= sk_d; di_q <= di_d; busy_q <= busy_d;
      edge_q <= edge_d; sh_q <= sh_d; sum_q <= sum_d;
    end
  end

  assign ee_cs = cs_q;
  assign ee_sk = sk_q;
  assign ee_di = di_q;
  assign busy  = busy_q;
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
  import cfgld_pkg::*;
#(
  parameter int unsigned WIW     = 4,
  parameter logic [15:0] ID_BASE = 16'h0C80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WIW-1:0]    word_idx,
  input  logic [WORD_W-1:0] word_data,
  input  logic              commit,
  input  logic              host_rd,
  input  logic [15:0]       host_addr,
  output logic [31:0]       id_bytes,
  output logic              aprom_en,
  output logic              id_win_en,
  output logic              host_hit,
  output logic [7:0]        host_data
);
  logic [31:0] id_sh_q, id_q;
  logic        aprom_sh_q, win_sh_q, aprom_q, win_q;

  for (genvar g = 0; g < 2; g++) begin : g_idw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  id_sh_q[16*g +: 16] <= '0;
      else if (word_vld && word_idx == WIW'(g))    id_sh_q[16*g +: 16] <= word_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aprom_sh_q <= 1'b0; win_sh_q <= 1'b0;
    end else if (word_vld && word_idx == WIW'(W_CTRL)) begin
      aprom_sh_q <= word_data[CTRL_APROM_BIT];
      win_sh_q   <= word_data[CTRL_IDWIN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0; aprom_q <= 1'b0; win_q <= 1'b0;
    end else if (commit) begin
      id_q <= id_sh_q; aprom_q <= aprom_sh_q; win_q <= win_sh_q;
    end
  end

  always_comb begin
    host_hit  = host_rd && win_q && (host_addr[15:2] == ID_BASE[15:2]);
    host_data = host_hit ? id_q[8*host_addr[1:0] +: 8] : 8'h00;
  end

  assign id_bytes  = id_q;
  assign aprom_en  = aprom_q;
  assign id_win_en = win_q;
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
  parameter int unsigned DIV     = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned NWORDS  = 8,
  parameter logic [15:0] SUM_OK  = 16'hBABA,
  parameter logic [15:0] ID_BASE = 16'h0C80
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic        ld_busy,
  output logic [31:0] id_bytes,
  output logic        aprom_en,
  output logic        id_win_en,
  input  logic        host_rd,
  input  logic [15:0] host_addr,
  output logic        host_hit,
  output logic [7:0]  host_data
);
  localparam int unsigned TOTAL = 4 + ADDR_W + 16 * NWORDS;
  localparam int unsigned WIW   = $clog2(TOTAL + 1) - 4;

  logic [1:0]     rsync_q;
  logic           rst_ni, tick, word_vld, pass;
  logic [WIW-1:0] word_idx;
  logic [15:0]    word_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  cfgld_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_ni), .tick(tick));

  cfgld_seq #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .SUM_OK(SUM_OK)) u_seq (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .word_vld(word_vld), .word_idx(word_idx), .word_data(word_data),
    .pass(pass), .busy(ld_busy)
  );

  cfgld_regs #(.WIW(WIW), .ID_BASE(ID_BASE)) u_regs (
    .clk(clk), .rst_n(rst_ni), .word_vld(word_vld), .word_idx(word_idx),
    .word_data(word_data), .commit(pass), .host_rd(host_rd),
    .host_addr(host_addr), .id_bytes(id_bytes), .aprom_en(aprom_en),
    .id_win_en(id_win_en), .host_hit(host_hit), .host_data(host_data)
  );
endmodule

// File: rtl/cfg_eeprom_loader_chk.sv
module cfg_eeprom_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ld_busy,
  input logic [31:0] id_bytes,
  input logic        aprom_en,
  input logic        id_win_en,
  input logic        host_hit,
  input logic [7:0]  host_data
);
  // R5
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_cs |-> ld_busy);
  // R5
  busy_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !ld_busy |=> !ld_busy);
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |-> (id_bytes == 32'h0 && !aprom_en && !id_win_en));
  // R2
  sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !ee_cs |-> !ee_sk);
  // R8
  win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) host_hit |-> id_win_en);
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !host_hit |-> host_data == 8'h00);
endmodule

bind cfg_eeprom_loader cfg_eeprom_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ld_busy(ld_busy),
  .id_bytes(id_bytes), .aprom_en(aprom_en), .id_win_en(id_win_en),
  .host_hit(host_hit), .host_data(host_data)
);

// File: tb/cfg_eeprom_loader_test.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_test;
  localparam int DIV = 2, AW = 6, NW = 6;
  localparam logic [15:0] SUM_OK = 16'hBABA;
  localparam int CMD_W = 3 + AW;
  localparam int TOTAL = CMD_W + 1 + 16 * NW;
  localparam int CB = 16 * (NW - 4);

  logic clk = 1'b0, rst_n = 1'b0, ee_do;
  logic ee_cs, ee_sk, ee_di, ld_busy, aprom_en, id_win_en, host_rd, host_hit;
  logic [31:0] id_bytes;
  logic [15:0] host_addr;
  logic [7:0]  host_data;

  int errs = 0, checks = 0, cyc = 0;
  logic [15:0] img [NW];

  always #2 clk = ~clk;

  cfg_eeprom_loader #(.DIV(DIV), .ADDR_W(AW), .NWORDS(NW), .SUM_OK(SUM_OK),
                      .ID_BASE(16'h0C80)) uut (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .ld_busy(ld_busy), .id_bytes(id_bytes), .aprom_en(aprom_en),
    .id_win_en(id_win_en), .host_rd(host_rd), .host_addr(host_addr),
    .host_hit(host_hit), .host_data(host_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model: command capture and data stream on rising serial clock
  int e;
  logic [CMD_W-1:0] cmd_rx;
  always @(posedge ee_sk or negedge rst_n) begin
    if (!rst_n) begin
      e <= 0; ee_do <= 1'b0; cmd_rx <= '0;
    end else if (ee_cs) begin
      int b;
      if (e < CMD_W) cmd_rx <= {cmd_rx[CMD_W-2:0], ee_di};
      if (e == CMD_W - 1) ee_do <= 1'b0;
      else if (e >= CMD_W) begin
        b = e - CMD_W;
        ee_do <= (b < 16 * NW) ? img[b / 16][15 - (b % 16)] : 1'b0;
      end
      e <= e + 1;
    end
  end

  // External chain shift register latched by the falling busy line
  logic [CB-1:0] ext_sr, ext_latch;
  always @(posedge ee_sk or negedge rst_n)
    if (!rst_n) ext_sr <= '0; else ext_sr <= {ext_sr[CB-2:0], ee_do};
  always @(negedge ld_busy) ext_latch <= ext_sr;

  // Per-clock reference of the serial timing and busy behaviour
  logic prev_cs, prev_sk, prev_busy;
  int ph, rises, cs_fall_cyc, busy_fall_cyc;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_cs = 1'b0; prev_sk = 1'b0; prev_busy = 1'b1; ph = 0; rises = 0;
      cs_fall_cyc = -1; busy_fall_cyc = -1;
    end else begin
      if (ee_sk != prev_sk) begin
        if (prev_cs) chk(ph == DIV, "R2 phase", ph, DIV);
        if (ee_sk) rises++;
        ph = 1;
      end else if (ee_cs && !prev_cs) ph = 1;
      else ph++;
      if (!ee_cs && ee_sk) chk(0, "R2 idle clock", 1, 0);
      if (ee_cs && !ld_busy) chk(0, "R5 busy during read", 0, 1);
      if (ld_busy && (id_bytes != 0 || aprom_en || id_win_en))
        chk(0, "R7 outputs before pass", id_bytes, 0);
      if (prev_cs && !ee_cs) cs_fall_cyc = cyc;
      if (prev_busy && !ld_busy) begin
        busy_fall_cyc = cyc;
        chk(cyc == cs_fall_cyc + 1, "R5 busy fall timing", cyc - cs_fall_cyc, 1);
      end
      if (!prev_busy && ld_busy) chk(0, "R5 busy rose again", 1, 0);
      prev_cs = ee_cs; prev_sk = ee_sk; prev_busy = ld_busy;
    end
  end

  task automatic build(input logic [15:0] w0, w1, w2, w4, w5, input bit corrupt);
    logic [15:0] s;
    img[0] = w0; img[1] = w1; img[2] = w2; img[4] = w4; img[5] = w5;
    s = w0 + w1 + w2 + w4 + w5;
    img[3] = SUM_OK - s + (corrupt ? 16'h0001 : 16'h0000);
  endtask

  task automatic load(input string tag);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ld_busy === 1'b1 && ee_cs === 1'b0 && ee_sk === 1'b0 && ee_di === 1'b0,
        "R1 reset pins", {ld_busy, ee_cs, ee_sk, ee_di}, 4'b1000);
    chk(id_bytes === 32'h0 && aprom_en === 1'b0 && id_win_en === 1'b0,
        "R1 reset config", id_bytes, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_busy === 1'b1 && ee_cs === 1'b0, "R1 after release", {ld_busy, ee_cs}, 2'b10);
    for (int i = 0; i < 4 * TOTAL * DIV + 100 && cs_fall_cyc < 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cs_fall_cyc >= 0, {"R4 chip select fell ", tag}, cs_fall_cyc, 1);
    chk(rises == TOTAL, {"R4 edge count ", tag}, rises, TOTAL);
    chk(cmd_rx == {3'b110, {AW{1'b0}}}, {"R3 command ", tag}, cmd_rx, {3'b110, {AW{1'b0}}});
  endtask

  task automatic host_check(input logic [15:0] a, input bit exp_hit, input logic [7:0] exp_d, input string req);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1;
    chk(host_hit === exp_hit && host_data === exp_d, req, {host_hit, host_data}, {exp_hit, exp_d});
    host_rd = 1'b0;
  endtask

  initial begin
    host_rd = 1'b0; host_addr = 16'h0;
    for (int i = 0; i < NW; i++) img[i] = 16'h0;

    // Good image, window enabled, address PROM enabled
    build(16'h3412, 16'h7856, 16'h0401, 16'hA5C3, 16'h0FF0, 1'b0);
    load("A");
    chk(ld_busy === 1'b0, "R5 busy low on pass", ld_busy, 0);
    chk(id_bytes === 32'h78563412, "R7 id bytes A", id_bytes, 32'h78563412);
    chk(aprom_en === 1'b1 && id_win_en === 1'b1, "R7 control A", {aprom_en, id_win_en}, 2'b11);
    chk(ext_latch === {16'hA5C3, 16'h0FF0}, "R9 chain A", ext_latch, {16'hA5C3, 16'h0FF0});
    host_check(16'h0C80, 1'b1, 8'h12, "R8 byte0");
    host_check(16'h0C81, 1'b1, 8'h34, "R8 byte1");
    host_check(16'h0C82, 1'b1, 8'h56, "R8 byte2");
    host_check(16'h0C83, 1'b1, 8'h78, "R8 byte3");
    host_check(16'h0C84, 1'b0, 8'h00, "R8 above window");
    host_check(16'h0C7F, 1'b0, 8'h00, "R8 below window");
    repeat (20) @(negedge clk);
    chk(ld_busy === 1'b0, "R5 busy stays low", ld_busy, 0);

    // Corrupted checksum word
    build(16'h3412, 16'h7856, 16'h0401, 16'hA5C3, 16'h0FF0, 1'b1);
    load("B");
    repeat (200) @(negedge clk);
    chk(ld_busy === 1'b1, "R6 busy held on bad sum", ld_busy, 1);
    chk(busy_fall_cyc < 0, "R6 no busy fall", busy_fall_cyc, -1);
    chk(id_bytes === 32'h0 && aprom_en === 1'b0 && id_win_en === 1'b0,
        "R6 config kept at reset", id_bytes, 0);
    host_check(16'h0C80, 1'b0, 8'h00, "R6 window closed after bad sum");

    // Good image, window disabled, different values
    build(16'hBEEF, 16'hCAFE, 16'h0000, 16'h1234, 16'hFFFF, 1'b0);
    load("C");
    chk(ld_busy === 1'b0, "R5 busy low on pass C", ld_busy, 0);
    chk(id_bytes === 32'hCAFEBEEF, "R7 id bytes C", id_bytes, 32'hCAFEBEEF);
    chk(aprom_en === 1'b0 && id_win_en === 1'b0, "R7 control C", {aprom_en, id_win_en}, 2'b00);
    chk(ext_latch === {16'h1234, 16'hFFFF}, "R9 chain C", ext_latch, {16'h1234, 16'hFFFF});
    host_check(16'h0C81, 1'b0, 8'h00, "R8 window disabled");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule